// File: doc/BRIEF.md
# Bus Interrupter with Loadable Status/ID Vector

This block is the interrupter side of a backplane board. A local agent raises a request with a set strobe and withdraws it with a clear strobe. While a request is pending, the block asserts one of seven interrupt request lines. Configuration picks the line, and a configured level of zero keeps the interrupter silent.

When a handler runs an interrupt-acknowledge cycle, it presents a 3-bit level code on the low address lines and sends the acknowledge down the daisy chain. If the code equals the configured level and a request is pending, the block claims the cycle. It drives its 8-bit status/ID vector on data bits 7..0 and signals data acknowledge for as long as the data strobe stays active. In every other case the chain acknowledge is passed on to the next board. The vector comes from a register that another bus master writes; only the low byte of the written word is kept.

Top module: `vme_irq_responder`

## Requirements
- R1: After reset no IRQ line is asserted, the data bus is not driven (`data_o` is 0, `data_oe_o` is 0), `dtack_o` is 0, and `iack_o` follows `iack_i`.
- R2: In the cycle after `req_set` is sampled, and with `cfg_level` = L in 1..7, `irq_o` has exactly bit L-1 set. At most one IRQ bit is ever set.
- R3: With `cfg_level` = 0, no IRQ bit is set and no acknowledge cycle is claimed, even when a request is pending.
- R4: `req_clr` withdraws a pending request. When `req_set` and `req_clr` are sampled in the same cycle, the clear wins.
- R5: A write with `vec_wr` loads bits 7..0 of `vec_wdata` as the vector. Bits 15..8 are ignored.
- R6: A cycle is claimed when four conditions hold at the same clock edge: `iack_i` is 1, `ds_i` is 1, a request is pending, and `ack_level` equals `cfg_level`. From the next cycle the block drives the vector on `data_o` with `data_oe_o` = 1 and holds `iack_o` at 0.
- R7: When no request is pending, or `ack_level` differs from `cfg_level`, `iack_o` equals `iack_i` and the data bus is not driven.
- R8: `dtack_o` is 1 only while the vector is driven and `ds_i` is 1. A matching level without `ds_i`, or without `iack_i`, is not claimed.
- R9: When `ds_i` falls during a claimed cycle, the pending request is released at the next edge. `irq_o` returns to 0 and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 3 | Configured request level, 0 = disabled |
| vec_wr | input | 1 | Vector register write strobe |
| vec_wdata | input | 16 | Vector register write word; low byte is the vector |
| req_set | input | 1 | Local request set strobe |
| req_clr | input | 1 | Local request clear strobe |
| iack_i | input | 1 | Daisy-chain acknowledge in, 1 = active |
| ds_i | input | 1 | Data strobe, 1 = active |
| ack_level | input | 3 | Level code from the low address lines during acknowledge |
| irq_o | output | 7 | Request lines, bit k = level k+1, 1 = asserted |
| iack_o | output | 1 | Daisy-chain acknowledge out, 1 = active |
| data_o | output | 8 | Vector on data bits 7..0 |
| data_oe_o | output | 1 | Data bus drive enable |
| dtack_o | output | 1 | Data acknowledge, 1 = active |

## Verification
The hardest case to reach is the release edge. The data strobe has to drop while the block is driving its vector, and only then should the request, the drive and the acknowledge all clear together. The stimulus gets there by first loading a vector, then raising a request, then opening an acknowledge cycle at the matching level and holding the strobe for two cycles before releasing it. A scoreboard queue records the vector expected for each claimed cycle. Cycles at other levels, cycles with the strobe or chain input missing, and cycles with the level set to zero must leave that queue untouched while the chain passes through.

// File: rtl/vme_irq_pkg.sv
package vme_irq_pkg;
  typedef enum logic {
    ACK_IDLE  = 1'b0,
    ACK_DRIVE = 1'b1
  } ack_state_e;
endpackage

// File: rtl/vir_vec_reg.sv
module vir_vec_reg #(
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [VEC_W-1:0]  vec_o
);
  logic [VEC_W-1:0] vec_q, vec_d;

  always_comb begin
    vec_d = vec_q;
    if (wr_en) vec_d = wdata[VEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/vir_req_track.sv
module vir_req_track #(
  parameter int LEVEL_W    = 3,
  parameter int NUM_LEVELS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic               ack_done_i,
  input  logic [LEVEL_W-1:0] cfg_level_i,
  output logic               pending_o,
  output logic [NUM_LEVELS-1:0] irq_o
);
  logic pend_q, pend_d;

  // clear and acknowledge completion take priority over a set
  always_comb begin
    pend_d = pend_q;
    if (set_i)               pend_d = 1'b1;
    if (clr_i || ack_done_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_line
    assign irq_o[g] = pend_q && (cfg_level_i == LEVEL_W'(g + 1));
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/vir_ack_ctrl.sv
module vir_ack_ctrl
  import vme_irq_pkg::*;
#(
  parameter int LEVEL_W = 3,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pending_i,
  input  logic [LEVEL_W-1:0] cfg_level_i,
  input  logic               iack_i,
  input  logic               ds_i,
  input  logic [LEVEL_W-1:0] ack_level_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic               iack_o,
  output logic [VEC_W-1:0]   data_o,
  output logic               data_oe_o,
  output logic               dtack_o,
  output logic               ack_done_o
);
  ack_state_e st_q, st_d;
  logic       enabled, claim;

  assign enabled = (cfg_level_i != '0);
  assign claim   = pending_i && enabled && (ack_level_i == cfg_level_i);

  always_comb begin
    st_d       = st_q;
    ack_done_o = 1'b0;
    case (st_q)
      ACK_IDLE:  if (iack_i && ds_i && claim) st_d = ACK_DRIVE;
      ACK_DRIVE: if (!ds_i) begin
        st_d       = ACK_IDLE;
        ack_done_o = 1'b1;
      end
      default:   st_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ACK_IDLE;
    else        st_q <= st_d;
  end

  assign data_oe_o = (st_q == ACK_DRIVE);
  assign data_o    = data_oe_o ? vec_i : '0;
  assign dtack_o   = data_oe_o && ds_i;
  assign iack_o    = iack_i && (st_q == ACK_IDLE) && !claim;
endmodule

// File: rtl/vme_irq_responder.sv
module vme_irq_responder #(
  parameter int LEVEL_W    = 3,
  parameter int NUM_LEVELS = 7,
  parameter int VEC_W      = 8,
  parameter int WORD_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEVEL_W-1:0]    cfg_level,
  input  logic                  vec_wr,
  input  logic [WORD_W-1:0]     vec_wdata,
  input  logic                  req_set,
  input  logic                  req_clr,
  input  logic                  iack_i,
  input  logic                  ds_i,
  input  logic [LEVEL_W-1:0]    ack_level,
  output logic [NUM_LEVELS-1:0] irq_o,
  output logic                  iack_o,
  output logic [VEC_W-1:0]      data_o,
  output logic                  data_oe_o,
  output logic                  dtack_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [VEC_W-1:0]       vec;
  logic                   pending, ack_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  vir_vec_reg #(.WORD_W(WORD_W), .VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_int_n), .wr_en(vec_wr), .wdata(vec_wdata), .vec_o(vec)
  );

  vir_req_track #(.LEVEL_W(LEVEL_W), .NUM_LEVELS(NUM_LEVELS)) u_req (
    .clk(clk), .rst_n(rst_int_n), .set_i(req_set), .clr_i(req_clr),
    .ack_done_i(ack_done), .cfg_level_i(cfg_level),
    .pending_o(pending), .irq_o(irq_o)
  );

  vir_ack_ctrl #(.LEVEL_W(LEVEL_W), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst_n(rst_int_n), .pending_i(pending), .cfg_level_i(cfg_level),
    .iack_i(iack_i), .ds_i(ds_i), .ack_level_i(ack_level), .vec_i(vec),
    .iack_o(iack_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .dtack_o(dtack_o), .ack_done_o(ack_done)
  );
endmodule

// File: rtl/vir_checker.sv
module vir_checker #(
  parameter int LEVEL_W    = 3,
  parameter int NUM_LEVELS = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LEVEL_W-1:0]    cfg_level,
  input logic                  iack_i,
  input logic                  ds_i,
  input logic [NUM_LEVELS-1:0] irq_o,
  input logic                  iack_o,
  input logic                  data_oe_o,
  input logic                  dtack_o
);
  // R2
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));
  // R3
  lvl0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level == '0) |-> (irq_o == '0));
  // R8
  dtack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dtack_o |-> (ds_i && data_oe_o));
  // R6
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> !iack_o);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && !ds_i) |=> ((irq_o == '0) && !data_oe_o));
  // R7
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_oe_o && (irq_o == '0)) |-> (iack_o == iack_i));
endmodule

bind vme_irq_responder vir_checker #(.LEVEL_W(LEVEL_W), .NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .iack_i(iack_i), .ds_i(ds_i),
  .irq_o(irq_o), .iack_o(iack_o), .data_oe_o(data_oe_o), .dtack_o(dtack_o)
);

// File: tb/tb_vme_irq_responder.sv
module tb_vme_irq_responder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_level, ack_level;
  logic        vec_wr, req_set, req_clr, iack_i, ds_i;
  logic [15:0] vec_wdata;
  logic [6:0]  irq_o;
  logic        iack_o, data_oe_o, dtack_o;
  logic [7:0]  data_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic dt_prev = 1'b0;

  always #2 clk = ~clk;

  vme_irq_responder dut (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .vec_wr(vec_wr),
    .vec_wdata(vec_wdata), .req_set(req_set), .req_clr(req_clr),
    .iack_i(iack_i), .ds_i(ds_i), .ack_level(ack_level), .irq_o(irq_o),
    .iack_o(iack_o), .data_o(data_o), .data_oe_o(data_oe_o), .dtack_o(dtack_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: one vector per claimed cycle (R6)
  always @(negedge clk) begin
    if (dtack_o && !dt_prev) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 act=%0h exp=none", data_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (data_o !== e) begin
          fails++;
          $display("FAIL R6 act=%0h exp=%0h", data_o, e);
        end
      end
    end
    dt_prev = dtack_o;
  end

  task automatic write_vec(logic [15:0] w);
    vec_wr = 1'b1; vec_wdata = w; tick(); vec_wr = 1'b0;
  endtask

  task automatic raise();
    req_set = 1'b1; tick(); req_set = 1'b0;
  endtask

  // acknowledge cycle; exp_claim pushes the expected vector
  task automatic ack_cycle(logic [2:0] code, bit exp_claim, logic [7:0] v, string req);
    ack_level = code; iack_i = 1'b1; ds_i = 1'b1;
    if (exp_claim) exp_q.push_back(v);
    tick();
    chk(req, {31'd0, data_oe_o}, {31'd0, exp_claim});
    chk(req, {31'd0, iack_o}, {31'd0, !exp_claim});
    tick();
    chk("R8", {31'd0, dtack_o}, {31'd0, exp_claim});
    ds_i = 1'b0; iack_i = 1'b0;
    tick();
    chk("R8", {31'd0, dtack_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_level = 3'd0; ack_level = 3'd0; vec_wr = 1'b0;
    vec_wdata = '0; req_set = 1'b0; req_clr = 1'b0; iack_i = 1'b0; ds_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // R1 reset state
    iack_i = 1'b1; #1;
    chk("R1", {25'd0, irq_o}, 32'd0);
    chk("R1", {31'd0, data_oe_o}, 32'd0);
    chk("R1", {24'd0, data_o}, 32'd0);
    chk("R1", {31'd0, dtack_o}, 32'd0);
    chk("R1", {31'd0, iack_o}, 32'd1);
    iack_i = 1'b0;

    // R5 vector low byte, R2 level 3
    write_vec(16'hA53C);
    cfg_level = 3'd3;
    raise();
    chk("R2", {25'd0, irq_o}, 32'h04);
    // R7 mismatched level passes chain
    ack_cycle(3'd5, 1'b0, 8'h00, "R7");
    chk("R7", {25'd0, irq_o}, 32'h04);
    // R8 matching level but no data strobe
    ack_level = 3'd3; iack_i = 1'b1; ds_i = 1'b0; tick();
    chk("R8", {31'd0, data_oe_o}, 32'd0);
    chk("R8", {31'd0, dtack_o}, 32'd0);
    // R8 matching level but chain input inactive
    iack_i = 1'b0; ds_i = 1'b1; tick();
    chk("R8", {31'd0, data_oe_o}, 32'd0);
    ds_i = 1'b0; tick();
    // R6 claimed cycle with vector 3C (R5 upper byte dropped), R9 release
    ack_cycle(3'd3, 1'b1, 8'h3C, "R6");
    chk("R9", {25'd0, irq_o}, 32'd0);
    chk("R9", {31'd0, data_oe_o}, 32'd0);
    // R7 no pending: matching level passes
    ack_cycle(3'd3, 1'b0, 8'h00, "R7");

    // R2 every level
    for (int l = 1; l <= 7; l++) begin
      cfg_level = 3'(l); raise();
      chk("R2", {25'd0, irq_o}, 32'(1 << (l - 1)));
      req_clr = 1'b1; tick(); req_clr = 1'b0;
      chk("R4", {25'd0, irq_o}, 32'd0);
    end

    // R4 simultaneous set and clear
    cfg_level = 3'd2;
    req_set = 1'b1; req_clr = 1'b1; tick(); req_set = 1'b0; req_clr = 1'b0;
    chk("R4", {25'd0, irq_o}, 32'd0);
    ack_cycle(3'd2, 1'b0, 8'h00, "R4");

    // R3 level zero
    cfg_level = 3'd0; raise();
    chk("R3", {25'd0, irq_o}, 32'd0);
    ack_cycle(3'd0, 1'b0, 8'h00, "R3");
    req_clr = 1'b1; tick(); req_clr = 1'b0;

    // R6 level 7 with new vector
    write_vec(16'h00FF);
    cfg_level = 3'd7; raise();
    chk("R2", {25'd0, irq_o}, 32'h40);
    ack_cycle(3'd7, 1'b1, 8'hFF, "R6");
    chk("R9", {25'd0, irq_o}, 32'd0);

    tick();
    chk("R6", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule